// File: doc/BRIEF.md
# Nine-Bit Serial Transmitter

This block turns one character at a time into an asynchronous serial frame on a single output line. Software writes a character into a one-entry holding buffer. When the shift stage is free, the buffer contents move into it, and the buffer-empty flag rises so that the next character can be written while the current one is still shifting out. A frame is a low start bit, then eight data bits sent least significant bit first, then an optional ninth bit, then one or two high stop bits. The ninth bit's value comes from a configuration input and not from the written data.

Bit timing comes from an external tick, and every serial bit lasts a fixed number of ticks (16 by default). The frame format is captured when the buffer hands its character to the shift stage. A frame already in flight is therefore not affected by later changes to the format inputs. When the buffer has a character waiting at the end of a frame, the next start bit follows the last stop bit with no gap. An interrupt request follows the buffer-empty flag and is gated by an enable input.

Top module: `ser9_tx`

## Requirements
- R1: Out of reset, and whenever no frame is being sent, `txd` is high and `buf_empty` is 1.
- R2: A frame is one low start bit, then `wr_data` bit 0 through bit 7 in that order, then high stop bits.
- R3: Each serial bit lasts exactly 16 `bit_tick` pulses. The line changes only on a tick or when a frame starts.
- R4: With `cfg_nine`=1, a ninth data bit equal to `cfg_bit9` follows bit 7. With `cfg_nine`=0, the first stop bit directly follows bit 7.
- R5: With `cfg_two_stop`=1, two stop bits are sent, otherwise one. A waiting character starts right after the last stop bit, so consecutive start bits are 16*(10+`cfg_nine`+`cfg_two_stop`) ticks apart.
- R6: A write into an empty buffer clears `buf_empty` in the next cycle. When the shift stage is idle or finishing its last bit, the buffer hands over: `buf_empty` rises and the start bit appears at the same edge.
- R7: A write while the buffer holds a character that is not being handed over that cycle is ignored. That character is never sent.
- R8: A write in the same cycle as a hand-off is accepted, and `buf_empty` stays 0.
- R9: The format inputs are sampled at hand-off. Changing them during a frame does not alter that frame.
- R10: `irq` is 1 exactly when `irq_en` is 1 and `buf_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bit_tick | input | 1 | One-cycle pulse, 16 per serial bit |
| wr_stb | input | 1 | Write strobe for the holding buffer |
| wr_data | input | 8 | Character to send |
| cfg_nine | input | 1 | 1 selects nine data bits |
| cfg_two_stop | input | 1 | 1 selects two stop bits |
| cfg_bit9 | input | 1 | Value of the ninth data bit |
| irq_en | input | 1 | Interrupt enable |
| txd | output | 1 | Serial line |
| buf_empty | output | 1 | Holding buffer is free |
| irq | output | 1 | Transmit interrupt request |

## Verification
A buffer write and a buffer-to-shifter hand-off can fall in the same cycle. The bench provokes this by writing on two consecutive cycles into an idle block: the second write lands on the edge where the first character leaves the buffer. It then checks that `buf_empty` stays low while the start bit appears at that edge, and that both characters come out back to back, spaced by exactly one frame length in ticks. The same test flips `cfg_bit9` just after the hand-off, and each frame must carry the ninth-bit value in force at its own hand-off.

// File: rtl/ser9_pkg.sv
package ser9_pkg;
  // Format captured at hand-off.
  typedef struct packed {
    logic nine;
    logic two_stop;
    logic bit9;
  } txfmt_t;

  // Start bit plus the mandatory stop bit.
  localparam int unsigned FIXED_BITS = 2;
  // Optional ninth bit plus optional second stop bit.
  localparam int unsigned OPT_BITS = 2;
endpackage

// File: rtl/ser9_txbuf.sv
module ser9_txbuf #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              take,
  output logic              full,
  output logic [DATA_W-1:0] data
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q;
  logic              load_en;

  // A write is accepted when empty, or when the held entry leaves this cycle.
  assign load_en = wr_stb && (!full_q || take);

  always_comb begin
    full_d = full_q;
    if (take)    full_d = 1'b0;
    if (load_en) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) full_q <= 1'b0;
    else         full_q <= full_d;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)      data_q <= '0;
    else if (load_en) data_q <= wr_data;
  end

  assign full = full_q;
  assign data = data_q;
endmodule

// File: rtl/ser9_bittimer.sv
module ser9_bittimer #(
  parameter int unsigned OVERSAMPLE = 16
) (
  input  logic clk,
  input  logic rst_ni,
  input  logic restart,
  input  logic run,
  input  logic tick,
  output logic bit_end
);
  localparam int unsigned CW = (OVERSAMPLE > 1) ? $clog2(OVERSAMPLE) : 1;
  localparam logic [CW-1:0] LAST = CW'(OVERSAMPLE - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  assign cnt_en  = restart || (run && tick);
  assign bit_end = run && tick && (cnt_q == LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (restart)            cnt_d = '0;
    else if (cnt_q == LAST) cnt_d = '0;
    else                    cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/ser9_shifter.sv
module ser9_shifter
  import ser9_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              load,
  input  logic [DATA_W-1:0] data,
  input  txfmt_t            fmt,
  input  logic              bit_end,
  output logic              busy,
  output logic              last_bit,
  output logic              txd
);
  localparam int unsigned FRAME_W = DATA_W + FIXED_BITS + OPT_BITS;
  localparam int unsigned LW      = $clog2(FRAME_W);

  logic [FRAME_W-1:0] sh_q, sh_d, frame_vec;
  logic [LW-1:0]      left_q, left_d, left_init;
  logic               busy_q, busy_d;
  logic               step_en;

  // Positions beyond the data default high, so they act as stop bits or idle.
  always_comb begin
    frame_vec = '1;
    frame_vec[0] = 1'b0;
    for (int i = 0; i < int'(DATA_W); i++) frame_vec[i+1] = data[i];
    if (fmt.nine) frame_vec[DATA_W+1] = fmt.bit9;
  end

  assign left_init = LW'(DATA_W + FIXED_BITS - 1) + LW'(fmt.nine) + LW'(fmt.two_stop);
  assign step_en   = load || (bit_end && busy_q);

  always_comb begin
    sh_d   = sh_q;
    left_d = left_q;
    busy_d = busy_q;
    if (load) begin
      sh_d   = frame_vec;
      left_d = left_init;
      busy_d = 1'b1;
    end else begin
      sh_d = {1'b1, sh_q[FRAME_W-1:1]};
      if (left_q == '0) busy_d = 1'b0;
      else              left_d = left_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      busy_q <= 1'b0;
    end else if (step_en) begin
      sh_q   <= sh_d;
      left_q <= left_d;
      busy_q <= busy_d;
    end
  end

  assign busy     = busy_q;
  assign last_bit = busy_q && (left_q == '0);
  assign txd      = sh_q[0];
endmodule

// File: rtl/ser9_tx.sv
module ser9_tx
  import ser9_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_tick,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cfg_nine,
  input  logic              cfg_two_stop,
  input  logic              cfg_bit9,
  input  logic              irq_en,
  output logic              txd,
  output logic              buf_empty,
  output logic              irq
);
  logic [SYNC_STAGES-1:0] rst_sync_q;
  logic                   rst_ni;
  logic                   buf_full, busy, last_bit, bit_end, take;
  logic [DATA_W-1:0]      buf_data;
  txfmt_t                 fmt;

  // Assert asynchronously, release on the clock.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ni = rst_sync_q[SYNC_STAGES-1];

  assign fmt  = '{nine: cfg_nine, two_stop: cfg_two_stop, bit9: cfg_bit9};
  // Hand-off when idle, or chained onto the final tick of the last bit.
  assign take = buf_full && (!busy || (bit_end && last_bit));

  ser9_txbuf #(.DATA_W(DATA_W)) u_buf (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .wr_stb  (wr_stb),
    .wr_data (wr_data),
    .take    (take),
    .full    (buf_full),
    .data    (buf_data)
  );

  ser9_bittimer #(.OVERSAMPLE(OVERSAMPLE)) u_timer (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .restart (take),
    .run     (busy),
    .tick    (bit_tick),
    .bit_end (bit_end)
  );

  ser9_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk      (clk),
    .rst_ni   (rst_ni),
    .load     (take),
    .data     (buf_data),
    .fmt      (fmt),
    .bit_end  (bit_end),
    .busy     (busy),
    .last_bit (last_bit),
    .txd      (txd)
  );

  assign buf_empty = !buf_full;
  assign irq       = irq_en && buf_empty;
endmodule

// File: rtl/ser9_tx_chk.sv
module ser9_tx_chk (
  input logic clk,
  input logic rst_ni,
  input logic bit_tick,
  input logic wr_stb,
  input logic busy,
  input logic txd,
  input logic buf_empty,
  input logic irq
);
  assert_idle_mark_R1: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> txd);

  assert_hold_between_ticks_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (busy && !bit_tick) |=> $stable(txd));

  assert_write_fills_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_stb && buf_empty) |=> !buf_empty);

  assert_handoff_starts_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    $rose(buf_empty) |-> (!txd && busy));

  assert_collide_keeps_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_stb && !buf_empty && !busy) |=> !buf_empty);

  assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    irq |-> buf_empty);
endmodule

bind ser9_tx ser9_tx_chk u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .bit_tick  (bit_tick),
  .wr_stb    (wr_stb),
  .busy      (busy),
  .txd       (txd),
  .buf_empty (buf_empty),
  .irq       (irq)
);

// File: tb/ser9_tx_test.sv
module ser9_tx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bit_tick = 1'b0;
  logic       wr_stb = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cfg_nine = 1'b0, cfg_two_stop = 1'b0, cfg_bit9 = 1'b0, irq_en = 1'b0;
  logic       txd, buf_empty, irq;

  int total = 0, fails = 0;
  int tcnt = 0;
  int exp_len = 10;

  // Receiver model state
  logic        rx_on = 1'b0, prev_txd = 1'b1, rise_seen = 1'b0;
  int          rx_t0 = 0, rx_k = 0, frames = 0;
  int          last_fall = 0, prev_fall = 0, rise_tick = 0;
  logic [11:0] cap_w = '1;

  // Vector: {data, nine, two_stop, bit9}
  localparam logic [10:0] VEC [8] = '{
    {8'h55, 3'b000}, {8'hA3, 3'b101}, {8'h0F, 3'b110}, {8'hFF, 3'b010},
    {8'h00, 3'b101}, {8'h80, 3'b111}, {8'h01, 3'b000}, {8'h3C, 3'b100}
  };

  ser9_tx uut (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .wr_stb(wr_stb), .wr_data(wr_data),
    .cfg_nine(cfg_nine), .cfg_two_stop(cfg_two_stop), .cfg_bit9(cfg_bit9),
    .irq_en(irq_en), .txd(txd), .buf_empty(buf_empty), .irq(irq)
  );

  always #5 clk = ~clk;

  initial begin
    forever begin
      @(negedge clk);
      bit_tick = ~bit_tick;
    end
  end

  always @(posedge clk) if (bit_tick) tcnt <= tcnt + 1;

  // Samples each bit at its middle, counted in ticks from the start edge.
  always @(negedge clk) begin
    if (!rst_n) begin
      rx_on <= 1'b0;
      prev_txd <= 1'b1;
    end else begin
      prev_txd <= txd;
      if (!rx_on) begin
        if (prev_txd && !txd) begin
          rx_on <= 1'b1; rx_t0 <= tcnt; rx_k <= 0; cap_w <= '1;
          rise_seen <= 1'b0;
          prev_fall <= last_fall; last_fall <= tcnt;
        end
      end else begin
        if (!prev_txd && txd && !rise_seen) begin
          rise_seen <= 1'b1; rise_tick <= tcnt - rx_t0;
        end
        if (tcnt == rx_t0 + 8 + 16 * rx_k) begin
          cap_w[rx_k] <= txd;
          rx_k <= rx_k + 1;
          if (rx_k + 1 == exp_len) begin
            rx_on <= 1'b0;
            frames <= frames + 1;
          end
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [11:0] exp_frame(input logic [7:0] d, input logic nine, input logic b9);
    logic [11:0] e;
    e = '1;
    e[0] = 1'b0;
    e[8:1] = d;
    if (nine) e[9] = b9;
    return e;
  endfunction

  task automatic wait_ticks(input int n);
    repeat (2 * n) @(negedge clk);
  endtask

  task automatic wait_frames(input int n);
    while (frames < n) @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d);
    @(negedge clk);
    wr_stb = 1'b1; wr_data = d;
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  // Two writes on consecutive cycles into an idle block: the second hits the hand-off.
  task automatic b2b(input logic nine, input logic two, input logic [7:0] d1, input logic [7:0] d2);
    int n;
    cfg_nine = nine; cfg_two_stop = two; cfg_bit9 = 1'b1;
    exp_len = 10 + int'(nine) + int'(two);
    n = frames;
    @(negedge clk);
    wr_stb = 1'b1; wr_data = d1;
    @(negedge clk);
    wr_data = d2;
    @(negedge clk);
    wr_stb = 1'b0;
    chk(buf_empty == 1'b0, "R8 write at hand-off kept", buf_empty, 0);
    chk(txd == 1'b0, "R6 start bit at hand-off", txd, 0);
    cfg_bit9 = 1'b0;  // R9: must not reach the frame in flight
    wait_frames(n + 1);
    chk(cap_w == exp_frame(d1, nine, 1'b1), "R9 first frame keeps ninth bit", cap_w, exp_frame(d1, nine, 1'b1));
    wait_frames(n + 2);
    chk(cap_w == exp_frame(d2, nine, 1'b0), "R8 second frame data", cap_w, exp_frame(d2, nine, 1'b0));
    chk(last_fall - prev_fall == 16 * exp_len, "R5 frame spacing", last_fall - prev_fall, 16 * exp_len);
    wait_ticks(12);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // Reset state
    chk(txd == 1'b1, "R1 idle line", txd, 1);
    chk(buf_empty == 1'b1, "R1 empty after reset", buf_empty, 1);
    chk(irq == 1'b0, "R10 irq masked", irq, 0);
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R10 irq enabled when empty", irq, 1);

    // Hand-off timing and bit duration
    exp_len = 10; n = frames;
    @(negedge clk);
    wr_stb = 1'b1; wr_data = 8'h01;
    @(negedge clk);
    wr_stb = 1'b0;
    chk(buf_empty == 1'b0, "R6 buffer filled", buf_empty, 0);
    chk(txd == 1'b1, "R6 line still idle", txd, 1);
    chk(irq == 1'b0, "R10 irq drops when full", irq, 0);
    @(negedge clk);
    chk(buf_empty == 1'b1, "R6 empty at hand-off", buf_empty, 1);
    chk(txd == 1'b0, "R6 start bit begins", txd, 0);
    wait_frames(n + 1);
    chk(rise_tick == 16, "R3 start bit length in ticks", rise_tick, 16);
    chk(cap_w == exp_frame(8'h01, 1'b0, 1'b0), "R2 frame 01", cap_w, exp_frame(8'h01, 1'b0, 1'b0));
    wait_ticks(12);

    // Vector table
    for (int i = 0; i < 8; i++) begin
      logic [10:0] v;
      v = VEC[i];
      cfg_nine = v[2]; cfg_two_stop = v[1]; cfg_bit9 = v[0];
      exp_len = 10 + int'(v[2]) + int'(v[1]);
      n = frames;
      send(v[10:3]);
      wait_frames(n + 1);
      chk(cap_w == exp_frame(v[10:3], v[2], v[0]), "R2 R4 table frame", cap_w, exp_frame(v[10:3], v[2], v[0]));
      wait_ticks(12);
    end

    // Write while full is dropped
    cfg_nine = 1'b0; cfg_two_stop = 1'b0; exp_len = 10; n = frames;
    send(8'h11);
    repeat (2) @(negedge clk);
    send(8'h22);
    repeat (2) @(negedge clk);
    send(8'h33);
    chk(buf_empty == 1'b0, "R7 buffer still holds first waiting", buf_empty, 0);
    wait_frames(n + 1);
    chk(cap_w == exp_frame(8'h11, 1'b0, 1'b0), "R7 first frame", cap_w, exp_frame(8'h11, 1'b0, 1'b0));
    wait_frames(n + 2);
    chk(cap_w == exp_frame(8'h22, 1'b0, 1'b0), "R7 second frame not overwritten", cap_w, exp_frame(8'h22, 1'b0, 1'b0));
    wait_ticks(200);
    chk(frames == n + 2, "R7 dropped write never sent", frames, n + 2);
    chk(txd == 1'b1 && buf_empty == 1'b1, "R1 idle after queue drains", {txd, buf_empty}, 2'b11);

    // Collision and back-to-back spacing
    b2b(1'b1, 1'b1, 8'hC6, 8'h39);
    b2b(1'b0, 1'b0, 8'hA5, 8'h5A);
    b2b(1'b0, 1'b1, 8'h81, 8'h7E);
    b2b(1'b1, 1'b0, 8'h4D, 8'hB2);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule